// File: doc/BRIEF.md
# Constant-Weight Pipelined Linear Projection

This block computes one fully connected projection of a neural network layer: a vector of signed 8-bit activations goes in, and a vector of signed 8-bit results comes out. Each result is the dot product of the input vector with one row of a 4-bit signed weight matrix. The weights are frozen into the logic when the design is elaborated. No memory, register or port holds them at run time, and nothing generates a weight address or steps through a program. Each product is formed by a fixed network of one or two shifted copies of the activation. Zero weights produce no hardware at all. The products feed a registered binary adder tree, and the sum is then scaled back to 8 bits.

Vectors arrive on a valid/ready stream and leave on another. The datapath is a plain pipeline that accepts one vector per clock while the consumer is ready. A single stall signal freezes every stage together when the consumer holds back. The block keeps no memory between vectors, so each result depends only on the vector that produced it.

The weight in row `o`, column `i` is `((5*o + 3*i + o*i) mod 16) - 8`, which gives values in -8..7. With the default parameters there are 8 inputs, 4 outputs and a scale shift of 3.

Top module: `hwl_linear_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Output lane `o` (bits `8*o+7 : 8*o` of `out_data`) equals `sat(floor((S + 2^(SHIFT-1)) / 2^SHIFT))`. Here `S` is the exact sum over i of `w(o,i) * x_i`, and `x_i` is input bits `8*i+7 : 8*i` read as two's complement.
- R3: A sum that lies exactly halfway between two output codes rounds toward plus infinity. With SHIFT=3, a sum of -20 gives -2 and a sum of +20 gives +3.
- R4: A scaled value above 127 gives 127, and a scaled value below -128 gives -128.
- R5: With `out_ready` held high and the pipeline empty, `out_valid` rises after the LAT-th rising edge, counting the edge that accepts the vector as the first. LAT = 2 + ceil(log2(N_IN)), which is 5 with the defaults.
- R6: While `out_ready` is high, `in_ready` is high, so a new vector is accepted on every clock.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid` and `out_data` hold their values. Every accepted vector leaves exactly once, in order.
- R8: The same input vector always gives the same output, whatever vectors came before it.
- R9: Vectors still in the pipeline when reset is asserted are discarded and never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stage valid flags only |
| in_valid | input | 1 | An input vector is presented |
| in_ready | output | 1 | The block takes the presented vector on this edge |
| in_data | input | 8*N_IN | Activations, element i at bits 8*i+7:8*i, two's complement |
| out_valid | output | 1 | A result vector is presented |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_data | output | 8*N_OUT | Results, lane o at bits 8*o+7:8*o, two's complement |

## Verification
Two things can happen in the same cycle: a new vector is accepted at the head of the pipeline while back-pressure at the tail decides whether that acceptance happens at all. The bench provokes this by streaming vectors back to back while it toggles `out_ready` at random. It judges the outcome with a scoreboard that must see every expected result exactly once and in order, and it checks that any result held during a stall stays unchanged. A second collision, reset arriving with vectors in flight, is provoked on purpose, and the output must then stay silent.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    localparam int ACT_W     = 8;
    localparam int WGT_W     = 4;
    localparam int DEF_N_IN  = 8;
    localparam int DEF_N_OUT = 4;
    localparam int DEF_SHIFT = 3;

    typedef logic signed [ACT_W-1:0] act_t;
    typedef logic signed [WGT_W-1:0] wgt_t;

    // one signed-digit term: +/- (act << sh)
    typedef struct packed {
        logic       en;
        logic       neg;
        logic [1:0] sh;
    } term_t;

    // a 4-bit weight recoded into at most two terms
    typedef struct packed {
        term_t hi;
        term_t lo;
    } csd_t;

    function automatic int acc_width(input int n);
        return ACT_W + WGT_W + $clog2(n);
    endfunction

    // the frozen weight matrix, computed rather than tabulated
    function automatic wgt_t weight_of(input int o, input int i);
        int v;
        v = ((o * 5 + i * 3 + o * i) % 16) - 8;
        return wgt_t'(v);
    endfunction

    function automatic term_t mk_term(input logic neg, input int sh);
        term_t t;
        t.en  = 1'b1;
        t.neg = neg;
        t.sh  = 2'(sh);
        return t;
    endfunction

    // signed-digit recoding of a weight in -8..7
    function automatic csd_t csd_of(input wgt_t w);
        csd_t c;
        int   m;
        logic sgn;
        sgn = w[WGT_W-1];
        m   = sgn ? -int'(w) : int'(w);
        c   = '0;
        case (m)
            1: c.lo = mk_term(1'b0, 0);
            2: c.lo = mk_term(1'b0, 1);
            3: begin c.hi = mk_term(1'b0, 2); c.lo = mk_term(1'b1, 0); end
            4: c.lo = mk_term(1'b0, 2);
            5: begin c.hi = mk_term(1'b0, 2); c.lo = mk_term(1'b0, 0); end
            6: begin c.hi = mk_term(1'b0, 3); c.lo = mk_term(1'b1, 1); end
            7: begin c.hi = mk_term(1'b0, 3); c.lo = mk_term(1'b1, 0); end
            8: c.lo = mk_term(1'b0, 3);
            default: c = '0;
        endcase
        if (sgn) begin
            c.hi.neg = c.hi.en & ~c.hi.neg;
            c.lo.neg = c.lo.en & ~c.lo.neg;
        end
        return c;
    endfunction

    function automatic logic has_terms(input csd_t c);
        return c.hi.en | c.lo.en;
    endfunction

endpackage

// File: rtl/hwl_csd_mul.sv
module hwl_csd_mul
    import hwl_pkg::*;
#(
    parameter int   W_OUT = 15,
    parameter csd_t CSD   = '0
) (
    input  logic                    clk,
    input  logic                    en,
    input  act_t                    act,
    output logic signed [W_OUT-1:0] prod
);

    logic signed [W_OUT-1:0] ext;
    logic signed [W_OUT-1:0] t_hi;
    logic signed [W_OUT-1:0] t_lo;

    assign ext = {{(W_OUT-ACT_W){act[ACT_W-1]}}, act};

    if (CSD.hi.en) begin : g_hi
        if (CSD.hi.neg) begin : g_neg
            assign t_hi = -(ext <<< CSD.hi.sh);
        end else begin : g_pos
            assign t_hi = ext <<< CSD.hi.sh;
        end
    end else begin : g_hi_off
        assign t_hi = '0;
    end

    if (CSD.lo.en) begin : g_lo
        if (CSD.lo.neg) begin : g_neg
            assign t_lo = -(ext <<< CSD.lo.sh);
        end else begin : g_pos
            assign t_lo = ext <<< CSD.lo.sh;
        end
    end else begin : g_lo_off
        assign t_lo = '0;
    end

    always_ff @(posedge clk) begin
        if (en) begin
            prod <= t_hi + t_lo;
        end
    end

endmodule

// File: rtl/hwl_add_tree.sv
module hwl_add_tree #(
    parameter int N = 8,
    parameter int W = 15
) (
    input  logic                clk,
    input  logic                en,
    input  logic signed [W-1:0] leaf [N],
    output logic signed [W-1:0] root
);

    localparam int LEV = $clog2(N);
    localparam int P2  = 1 << LEV;

    // heap view: 1..P2-1 are registered sums, P2..2*P2-1 are leaves
    logic signed [W-1:0] nd [1:P2-1];
    logic signed [W-1:0] hp [1:2*P2-1];

    for (genvar k = 1; k < P2; k++) begin : g_inner
        assign hp[k] = nd[k];
    end

    for (genvar j = 0; j < P2; j++) begin : g_leaf
        if (j < N) begin : g_used
            assign hp[P2+j] = leaf[j];
        end else begin : g_pad
            assign hp[P2+j] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            for (int k = 1; k < P2; k++) begin
                nd[k] <= hp[2*k] + hp[2*k+1];
            end
        end
    end

    assign root = nd[1];

endmodule

// File: rtl/hwl_requant.sv
module hwl_requant
    import hwl_pkg::*;
#(
    parameter int W_IN  = 15,
    parameter int SHIFT = 3
) (
    input  logic                   clk,
    input  logic                   en,
    input  logic signed [W_IN-1:0] acc,
    output act_t                   q
);

    localparam logic signed [W_IN:0] HI_LIM = (W_IN+1)'(127);
    localparam logic signed [W_IN:0] LO_LIM = (W_IN+1)'(-128);

    logic signed [W_IN:0] wide;
    logic signed [W_IN:0] scaled;
    act_t                 sat;

    assign wide = {acc[W_IN-1], acc};

    if (SHIFT > 0) begin : g_round
        localparam logic signed [W_IN:0] HALF = (W_IN+1)'(1) <<< (SHIFT-1);
        assign scaled = (wide + HALF) >>> SHIFT;
    end else begin : g_pass
        assign scaled = wide;
    end

    always_comb begin
        if (scaled > HI_LIM) begin
            sat = 8'sh7f;
        end else if (scaled < LO_LIM) begin
            sat = 8'sh80;
        end else begin
            sat = scaled[ACT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            q <= sat;
        end
    end

endmodule

// File: rtl/hwl_linear_top.sv
module hwl_linear_top
    import hwl_pkg::*;
#(
    parameter int N_IN  = DEF_N_IN,
    parameter int N_OUT = DEF_N_OUT,
    parameter int SHIFT = DEF_SHIFT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [N_IN*ACT_W-1:0]  in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [N_OUT*ACT_W-1:0] out_data
);

    localparam int ACC_W  = acc_width(N_IN);
    localparam int LEVELS = $clog2(N_IN);
    localparam int LAT    = LEVELS + 2;

    logic           adv;
    logic [LAT-1:0] vld;
    act_t           act [N_IN];

    // one global advance: the whole pipeline moves or freezes together
    assign adv       = out_ready | ~out_valid;
    assign in_ready  = adv;
    assign out_valid = vld[LAT-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (adv) begin
            vld <= {vld[LAT-2:0], in_valid};
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_act
        assign act[i] = in_data[i*ACT_W +: ACT_W];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_row
        logic signed [ACC_W-1:0] leaf [N_IN];
        logic signed [ACC_W-1:0] sum;
        act_t                    q;

        for (genvar i = 0; i < N_IN; i++) begin : g_col
            localparam csd_t C = csd_of(weight_of(o, i));
            if (has_terms(C)) begin : g_mul
                hwl_csd_mul #(
                    .W_OUT (ACC_W),
                    .CSD   (C)
                ) u_mul (
                    .clk  (clk),
                    .en   (adv),
                    .act  (act[i]),
                    .prod (leaf[i])
                );
            end else begin : g_zero
                assign leaf[i] = '0;
            end
        end

        hwl_add_tree #(
            .N (N_IN),
            .W (ACC_W)
        ) u_tree (
            .clk  (clk),
            .en   (adv),
            .leaf (leaf),
            .root (sum)
        );

        hwl_requant #(
            .W_IN  (ACC_W),
            .SHIFT (SHIFT)
        ) u_rq (
            .clk (clk),
            .en  (adv),
            .acc (sum),
            .q   (q)
        );

        assign out_data[o*ACT_W +: ACT_W] = q;
    end

endmodule

// File: rtl/hwl_linear_chk.sv
module hwl_linear_chk #(
    parameter int N_OUT = 4,
    parameter int LAT   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [N_OUT*8-1:0] out_data
);

    int   inflight;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            inflight <= 0;
        end else begin
            inflight <= inflight + ((in_valid && in_ready) ? 1 : 0)
                                 - ((out_valid && out_ready) ? 1 : 0);
        end
    end

    always @(negedge clk) begin
        if (rst_q) begin
            AST_RESET_EMPTY: assert (!out_valid) else $error("valid after reset"); // R9
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R7

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready); // R6

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight > 0)); // R7

    AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
        inflight <= LAT); // R5

endmodule

bind hwl_linear_top hwl_linear_chk #(
    .N_OUT (N_OUT),
    .LAT   (LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_hwl_linear_top.sv
module test_hwl_linear_top;

    localparam int N_IN  = 8;
    localparam int N_OUT = 4;
    localparam int SH    = 3;
    localparam int LAT   = 2 + $clog2(N_IN);
    localparam int CLK_NS = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [N_IN*8-1:0]    in_data = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [N_OUT*8-1:0]   out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit stall_mode = 0;
    bit done = 0;

    logic [N_OUT*8-1:0] exp_q [$];
    string              tag_q [$];

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hwl_linear_top #(.N_IN(N_IN), .N_OUT(N_OUT), .SHIFT(SH)) i_hwl_linear_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic logic [N_OUT*8-1:0] ref_vec(input logic [N_IN*8-1:0] v);
        logic [N_OUT*8-1:0] r;
        r = '0;
        for (int o = 0; o < N_OUT; o++) begin
            int acc;
            int q;
            acc = 0;
            for (int i = 0; i < N_IN; i++) begin
                acc += int'(hwl_pkg::weight_of(o, i)) * int'($signed(v[i*8 +: 8]));
            end
            q = (acc + (1 <<< (SH-1))) >>> SH;
            if (q > 127) q = 127;
            if (q < -128) q = -128;
            r[o*8 +: 8] = 8'(q);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [N_IN*8-1:0] v, input string tag);
        bit taken;
        taken = 0;
        in_valid = 1'b1;
        in_data  = v;
        while (!taken) begin
            @(negedge clk);
            if (in_ready) begin
                taken = 1;
                exp_q.push_back(ref_vec(v));
                tag_q.push_back(tag);
            end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [N_IN*8-1:0] rand_vec();
        logic [N_IN*8-1:0] v;
        for (int i = 0; i < N_IN; i++) v[i*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [N_IN*8-1:0] fill(input logic [7:0] b);
        logic [N_IN*8-1:0] v;
        for (int i = 0; i < N_IN; i++) v[i*8 +: 8] = b;
        return v;
    endfunction

    // drive each element to the extreme matching the sign of row 0 weights
    function automatic logic [N_IN*8-1:0] sat_vec(input bit up);
        logic [N_IN*8-1:0] v;
        for (int i = 0; i < N_IN; i++) begin
            bit pos;
            pos = (hwl_pkg::weight_of(0, i) >= 0);
            v[i*8 +: 8] = (pos == up) ? 8'h7f : 8'h80;
        end
        return v;
    endfunction

    // back-pressure generator, changes only 1 ns after a rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard, samples on the falling edge
    logic [N_OUT*8-1:0] held;
    bit                 was_stalled = 0;
    always @(negedge clk) begin
        if (rst) begin
            was_stalled = 0;
        end else begin
            if (was_stalled) begin
                check(out_valid && out_data == held, "R7", "held data in stall",
                      longint'(out_data), longint'(held));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7", "unexpected output", longint'(out_data), 0);
                end else begin
                    logic [N_OUT*8-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, "result vector", longint'(out_data), longint'(e));
                end
            end
            was_stalled = out_valid && !out_ready;
            held = out_data;
        end
    end

    initial begin
        #(CLK_NS * 100000);
        failures++;
        checks++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N_IN*8-1:0] v;
        int n;
        int t0;

        // R1: reset state
        idle(2);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        idle(1);

        // R5: latency on an empty pipeline
        send(rand_vec(), "R5");
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!out_valid && n < 20);
        check(n == LAT, "R5", "latency edges", n, LAT);
        idle(LAT + 2);

        // R6: full rate with ready held high
        t0 = cyc;
        for (int k = 0; k < 16; k++) send(rand_vec(), "R6");
        check((cyc - t0) == 16, "R6", "cycles for 16 vectors", cyc - t0, 16);
        idle(LAT + 2);

        // R3: half-way ties (element 1 only; row 0 weight -5 gives -20 / +20)
        v = '0; v[15:8] = 8'sd4;
        send(v, "R3");
        v = '0; v[15:8] = -8'sd4;
        send(v, "R3");

        // R4: saturation both ways, R2: extreme uniform vectors
        send(sat_vec(1'b1), "R4");
        send(sat_vec(1'b0), "R4");
        send(fill(8'h7f), "R2");
        send(fill(8'h80), "R2");
        send(fill(8'h00), "R2");

        // random traffic under back-pressure (R2, R7)
        stall_mode = 1;
        for (int k = 0; k < 200; k++) send(rand_vec(), "R2");

        // R8: same vector around unrelated traffic
        v = rand_vec();
        send(v, "R8");
        send(fill(8'h80), "R2");
        send(rand_vec(), "R2");
        send(v, "R8");
        stall_mode = 0;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(posedge clk);
            n++;
        end
        #1;
        check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
        idle(2);

        // R9: reset with vectors in flight
        send(rand_vec(), "R9");
        send(rand_vec(), "R9");
        send(rand_vec(), "R9");
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        idle(2);
        rst = 1'b0;
        n = 0;
        for (int k = 0; k < LAT + 4; k++) begin
            @(negedge clk);
            if (out_valid) n++;
        end
        check(n == 0, "R9", "outputs after reset", n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule